// File: doc/BRIEF.md
# CAN Channel Mode and Status Register

This block is the control and status register of one CAN channel. Its low byte holds two mode bits (the operating mode and the diagnostic storage choice), two control bits (single-shot transmission and a bus-busy flag) and four status flags that the protocol engine raises: bus error, valid frame seen, wake-up and overrun. The upper byte is the write-command half of the register and always reads as zero.

Software never writes a bit directly. A 16-bit write carries, for each bit, a clear command in the low byte and, for the four mode and control bits, a set command in the upper byte. One bit can therefore be changed without reading the register first. An 8-bit write is ignored; 8-bit and 16-bit reads are both served. The four status flags can only be cleared by software. A hardware set pulse on the same cycle as a clear wins.

The two mode bits live in a four-state mode machine. The states are `MODE_NORM_D0`, `MODE_NORM_D1`, `MODE_DIAG_T7` and `MODE_DIAG_RX`, encoded as {operating-mode, storage-select}. The named transitions are ENTER_DIAG (operating-mode set), LEAVE_DIAG (operating-mode cleared), PICK_RX_STORE (storage-select set) and PICK_T7_STORE (storage-select cleared). When a write changes both bits at once, the diagonal moves combine these. From the state the block derives the gating signals for the protocol engine. It also guards the neighbouring baud-prescaler register: in diagnostic mode, outside the initialisation state, writes to the prescaler are blocked and prescaler reads return the diagnostic-info word.

Top module: `can_mode_reg`

## Requirements
- R1: After reset a 16-bit read returns 0001h: only the overrun flag (bit 0) is set, and the mode is normal.
- R2: Bits 15..8 always read zero. A 16-bit read returns the status byte in bits 7..0. An 8-bit read of the low lane returns the status byte, and an 8-bit read of the high lane returns 00h. With no read strobe the bus data is zero.
- R3: Read bit layout is 7 storage-select, 6 operating-mode, 5 single-shot, 4 bus-busy, 3 bus-error, 2 valid, 1 wake, 0 overrun. A 16-bit write with write bit (n+8) high and write bit n low sets bit n, for n = 4..7. Write bit n high with write bit (n+8) low clears bit n.
- R4: Bits 3..0 can only be cleared by software (write bit n clears bit n). Write bits 11..8 have no effect.
- R5: A write that asserts both the set and the clear command of a bit, or neither, leaves that bit unchanged.
- R6: A write with the 8-bit size (bus_wide = 0) changes no bit.
- R7: A hardware set pulse on hw_flag_set[3:0] (bit 3 bus-error down to bit 0 overrun) sets the flag, even when a software clear of that flag happens on the same cycle.
- R8: With operating-mode = 1, tx_enable = 0, ack_enable = 0 and errcnt_freeze = 1. With operating-mode = 0, the opposite values apply.
- R9: store_type7 is 1 only when operating-mode = 1 and storage-select = 0. Storage-select has no effect on any output while operating-mode = 0.
- R10: presc_wr_en follows a prescaler write strobe, except when operating-mode = 1 and init_state = 0, where it stays 0.
- R11: A prescaler-address read returns diag_rdata when operating-mode = 1 and init_state = 0, and presc_rdata otherwise.
- R12: A register write takes effect on the next rising clock edge and is visible on reads and outputs from then on. single_shot mirrors bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Access addresses this register |
| presc_sel | input | 1 | Access addresses the baud-prescaler register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_hi_byte | input | 1 | For 8-bit reads, selects the upper byte lane |
| bus_wdata | input | 16 | Write data (set byte high, clear byte low) |
| bus_rdata | output | 16 | Read data |
| init_state | input | 1 | Channel is in its initialisation state |
| presc_rdata | input | 16 | Prescaler register contents |
| diag_rdata | input | 16 | Diagnostic-info register contents |
| hw_flag_set | input | 4 | Hardware set pulses: bus-error, valid, wake, overrun |
| presc_wr_en | output | 1 | Gated prescaler write enable |
| tx_enable | output | 1 | Frame transmission allowed |
| ack_enable | output | 1 | Acknowledge generation allowed |
| errcnt_freeze | output | 1 | Error counters hold their values |
| store_type7 | output | 1 | Store valid frames in the type-7 buffer |
| single_shot | output | 1 | Single-shot transmission bit |

## Verification
A wrong mode state shows up on the very next cycle in two places: bits 7..6 of a read, and the four gating outputs together. A stuck state or a wrong diagonal transition is therefore seen by the first read after the write that should have moved it. A flag that keeps, drops or gains a value shows up on the next 16-bit read. Flipping priority between hardware set and software clear is seen only on cycles where both are asserted, so those cycles are driven deliberately as well as at random. A bad prescaler gate shows up within the same cycle, on presc_wr_en or on the read mux.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int BUS_W   = 16;
    localparam int STAT_W  = 8;
    localparam int HW_W    = 4;
    localparam int SET_OFS = 8;   // set command for bit n sits at n + SET_OFS
    localparam int SET_LO  = 4;   // lowest bit that has a set command

    localparam int B_DGM  = 7;
    localparam int B_MOM  = 6;
    localparam int B_SSHT = 5;

    localparam logic [STAT_W-1:0] STAT_RST = 8'h01;

    // encoding is {operating-mode, storage-select}
    typedef enum logic [1:0] {
        MODE_NORM_D0 = 2'b00,
        MODE_NORM_D1 = 2'b01,
        MODE_DIAG_T7 = 2'b10,
        MODE_DIAG_RX = 2'b11
    } mode_e;

    typedef struct packed {
        logic tx_en;
        logic ack_en;
        logic err_freeze;
        logic store_t7;
    } gate_t;

endpackage

// File: rtl/can_mode_bus.sv
module can_mode_bus
    import can_mode_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int SW = STAT_W
) (
    input  logic          reg_sel,
    input  logic          presc_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_wide,
    input  logic          bus_hi_byte,
    input  logic [DW-1:0] bus_wdata,
    input  logic          diag_mode,
    input  logic          init_state,
    input  logic [SW-1:0] status,
    input  logic [DW-1:0] presc_rdata,
    input  logic [DW-1:0] diag_rdata,
    output logic [SW-1:0] set_cmd,
    output logic [SW-1:0] clr_cmd,
    output logic          presc_wr_en,
    output logic [DW-1:0] bus_rdata
);

    localparam int PAD_W = DW - SW;

    logic wr_full;
    logic presc_lock;

    // only full-width writes reach the register
    assign wr_full    = reg_sel & bus_wr & bus_wide;
    assign presc_lock = diag_mode & ~init_state;

    for (genvar i = 0; i < SW; i++) begin : g_cmd
        assign clr_cmd[i] = wr_full & bus_wdata[i];
        if (i >= SET_LO) begin : g_set
            assign set_cmd[i] = wr_full & bus_wdata[i + SET_OFS];
        end else begin : g_noset
            assign set_cmd[i] = 1'b0;
        end
    end

    assign presc_wr_en = presc_sel & bus_wr & ~presc_lock;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && reg_sel) begin
            if (bus_wide || !bus_hi_byte) begin
                bus_rdata = {{PAD_W{1'b0}}, status};
            end
        end else if (bus_rd && presc_sel) begin
            bus_rdata = presc_lock ? diag_rdata : presc_rdata;
        end
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mom_set,
    input  logic  mom_clr,
    input  logic  dgm_set,
    input  logic  dgm_clr,
    output mode_e mode,
    output logic  mom,
    output logic  dgm,
    output gate_t gate
);

    mode_e state_q, state_d;
    logic  mom_up, mom_dn, dgm_up, dgm_dn;

    // a set together with a clear is no command
    assign mom_up = mom_set & ~mom_clr;
    assign mom_dn = mom_clr & ~mom_set;
    assign dgm_up = dgm_set & ~dgm_clr;
    assign dgm_dn = dgm_clr & ~dgm_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORM_D0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORM_D0: begin
                if (mom_up)      state_d = dgm_up ? MODE_DIAG_RX : MODE_DIAG_T7; // ENTER_DIAG
                else if (dgm_up) state_d = MODE_NORM_D1;                         // PICK_RX_STORE
            end
            MODE_NORM_D1: begin
                if (mom_up)      state_d = dgm_dn ? MODE_DIAG_T7 : MODE_DIAG_RX; // ENTER_DIAG
                else if (dgm_dn) state_d = MODE_NORM_D0;                         // PICK_T7_STORE
            end
            MODE_DIAG_T7: begin
                if (mom_dn)      state_d = dgm_up ? MODE_NORM_D1 : MODE_NORM_D0; // LEAVE_DIAG
                else if (dgm_up) state_d = MODE_DIAG_RX;                         // PICK_RX_STORE
            end
            MODE_DIAG_RX: begin
                if (mom_dn)      state_d = dgm_dn ? MODE_NORM_D0 : MODE_NORM_D1; // LEAVE_DIAG
                else if (dgm_dn) state_d = MODE_DIAG_T7;                         // PICK_T7_STORE
            end
            default: state_d = MODE_NORM_D0;
        endcase
    end

    always_comb begin
        mom  = 1'b0;
        dgm  = 1'b0;
        gate = '{tx_en: 1'b1, ack_en: 1'b1, err_freeze: 1'b0, store_t7: 1'b0};
        unique case (state_q)
            MODE_NORM_D0: begin
                mom = 1'b0; dgm = 1'b0;
            end
            MODE_NORM_D1: begin
                mom = 1'b0; dgm = 1'b1;
            end
            MODE_DIAG_T7: begin
                mom = 1'b1; dgm = 1'b0;
                gate = '{tx_en: 1'b0, ack_en: 1'b0, err_freeze: 1'b1, store_t7: 1'b1};
            end
            MODE_DIAG_RX: begin
                mom = 1'b1; dgm = 1'b1;
                gate = '{tx_en: 1'b0, ack_en: 1'b0, err_freeze: 1'b1, store_t7: 1'b0};
            end
            default: ;
        endcase
    end

    assign mode = state_q;

endmodule

// File: rtl/can_mode_flags.sv
module can_mode_flags #(
    parameter int              W     = 6,
    parameter int              HW    = 4,
    parameter logic [W-1:0]    RST_V = 6'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  set_cmd,
    input  logic [W-1:0]  clr_cmd,
    input  logic [HW-1:0] hw_set,
    output logic [W-1:0]  flags
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hw_i;
        if (i < HW) begin : g_hw
            assign hw_i = hw_set[i];
        end else begin : g_nohw
            assign hw_i = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= RST_V[i];
            end else if (hw_i) begin
                flags[i] <= 1'b1;
            end else if (set_cmd[i] && !clr_cmd[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_cmd[i] && !set_cmd[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/can_mode_reg.sv
module can_mode_reg
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              presc_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic              bus_hi_byte,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              init_state,
    input  logic [BUS_W-1:0]  presc_rdata,
    input  logic [BUS_W-1:0]  diag_rdata,
    input  logic [HW_W-1:0]   hw_flag_set,
    output logic              presc_wr_en,
    output logic              tx_enable,
    output logic              ack_enable,
    output logic              errcnt_freeze,
    output logic              store_type7,
    output logic              single_shot
);

    localparam int FLAG_W = STAT_W - 2;

    logic [STAT_W-1:0] set_cmd, clr_cmd;
    logic [STAT_W-1:0] status_q;
    logic [FLAG_W-1:0] flag_q;
    logic              mom, dgm;
    mode_e             mode;
    gate_t             gate;

    can_mode_bus #(.DW(BUS_W), .SW(STAT_W)) u_bus (
        .reg_sel     (reg_sel),
        .presc_sel   (presc_sel),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wide    (bus_wide),
        .bus_hi_byte (bus_hi_byte),
        .bus_wdata   (bus_wdata),
        .diag_mode   (mom),
        .init_state  (init_state),
        .status      (status_q),
        .presc_rdata (presc_rdata),
        .diag_rdata  (diag_rdata),
        .set_cmd     (set_cmd),
        .clr_cmd     (clr_cmd),
        .presc_wr_en (presc_wr_en),
        .bus_rdata   (bus_rdata)
    );

    can_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mom_set (set_cmd[B_MOM]),
        .mom_clr (clr_cmd[B_MOM]),
        .dgm_set (set_cmd[B_DGM]),
        .dgm_clr (clr_cmd[B_DGM]),
        .mode    (mode),
        .mom     (mom),
        .dgm     (dgm),
        .gate    (gate)
    );

    can_mode_flags #(.W(FLAG_W), .HW(HW_W), .RST_V(STAT_RST[FLAG_W-1:0])) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (set_cmd[FLAG_W-1:0]),
        .clr_cmd (clr_cmd[FLAG_W-1:0]),
        .hw_set  (hw_flag_set),
        .flags   (flag_q)
    );

    assign status_q      = {dgm, mom, flag_q};
    assign tx_enable     = gate.tx_en;
    assign ack_enable    = gate.ack_en;
    assign errcnt_freeze = gate.err_freeze;
    assign store_type7   = gate.store_t7;
    assign single_shot   = status_q[B_SSHT];

endmodule

// File: rtl/can_mode_reg_chk.sv
module can_mode_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        presc_sel,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_wide,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        init_state,
    input logic [3:0]  hw_flag_set,
    input logic        presc_wr_en,
    input logic        tx_enable,
    input logic        ack_enable,
    input logic        errcnt_freeze,
    input logic        store_type7,
    input logic [7:0]  status
);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && bus_rd) |-> (bus_rdata[15:8] == 8'h00));

    // R6
    narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && bus_wr && !bus_wide && hw_flag_set == 4'h0) |=> $stable(status));

    // R5
    conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && bus_wr && bus_wide && bus_wdata[14] && bus_wdata[6]) |=> $stable(status[6]));

    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flag_set != 4'h0) |=> ((status[3:0] & $past(hw_flag_set)) == $past(hw_flag_set)));

    // R8
    diag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (!tx_enable && !ack_enable && errcnt_freeze));

    // R9
    dgm_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6] |-> (!store_type7 && tx_enable && ack_enable));

    // R10
    presc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel && bus_wr && status[6] && !init_state) |-> !presc_wr_en);

endmodule

bind can_mode_reg can_mode_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_sel       (reg_sel),
    .presc_sel     (presc_sel),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wide      (bus_wide),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .init_state    (init_state),
    .hw_flag_set   (hw_flag_set),
    .presc_wr_en   (presc_wr_en),
    .tx_enable     (tx_enable),
    .ack_enable    (ack_enable),
    .errcnt_freeze (errcnt_freeze),
    .store_type7   (store_type7),
    .status        (status_q)
);

// File: tb/can_mode_reg_bench.sv
module can_mode_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, presc_sel = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b1, bus_hi_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        init_state = 1'b0;
    logic [15:0] presc_rdata = 16'h1234, diag_rdata = 16'hD1A6;
    logic [3:0]  hw_flag_set = '0;
    logic        presc_wr_en, tx_enable, ack_enable, errcnt_freeze, store_type7, single_shot;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] exp_st;

    always #4 clk = ~clk;

    can_mode_reg u_can_mode_reg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .presc_sel(presc_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_hi_byte(bus_hi_byte),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_state(init_state),
        .presc_rdata(presc_rdata), .diag_rdata(diag_rdata), .hw_flag_set(hw_flag_set),
        .presc_wr_en(presc_wr_en), .tx_enable(tx_enable), .ack_enable(ack_enable),
        .errcnt_freeze(errcnt_freeze), .store_type7(store_type7), .single_shot(single_shot)
    );

    function automatic logic [7:0] model_next(logic [7:0] old, logic [15:0] d,
                                              logic wide, logic [3:0] hw);
        logic [7:0] s, c, n;
        s = wide ? {d[15:12], 4'b0000} : 8'h00;
        c = wide ? d[7:0] : 8'h00;
        n = (old & ~(c & ~s)) | (s & ~c);
        n[3:0] = n[3:0] | hw;
        return n;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic do_write(logic [15:0] d, logic wide, logic [3:0] hw);
        @(negedge clk);
        reg_sel = 1'b1; bus_wr = 1'b1; bus_wide = wide; bus_wdata = d; hw_flag_set = hw;
        @(negedge clk);
        reg_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b1; hw_flag_set = '0;
        exp_st = model_next(exp_st, d, wide, hw);
    endtask

    // reads the register and checks every output against the model
    task automatic check_state(string req);
        reg_sel = 1'b1; bus_rd = 1'b1; bus_wide = 1'b1;
        #1;
        chk(req, bus_rdata, {8'h00, exp_st});
        chk({req, " gates"}, {12'h0, tx_enable, ack_enable, errcnt_freeze, store_type7},
            {12'h0, ~exp_st[6], ~exp_st[6], exp_st[6], exp_st[6] & ~exp_st[7]});
        chk({req, " single_shot"}, {15'h0, single_shot}, {15'h0, exp_st[5]});
        reg_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic check_narrow(logic hi);
        reg_sel = 1'b1; bus_rd = 1'b1; bus_wide = 1'b0; bus_hi_byte = hi;
        #1;
        chk("R2 byte read", bus_rdata, hi ? 16'h0000 : {8'h00, exp_st});
        reg_sel = 1'b0; bus_rd = 1'b0; bus_wide = 1'b1; bus_hi_byte = 1'b0;
    endtask

    task automatic check_presc(logic init);
        logic lock;
        lock = exp_st[6] & ~init;
        init_state = init; presc_sel = 1'b1; bus_wr = 1'b1;
        #1;
        chk("R10 prescaler write gate", {15'h0, presc_wr_en}, {15'h0, ~lock});
        bus_wr = 1'b0; bus_rd = 1'b1;
        #1;
        chk("R11 prescaler read mux", bus_rdata, lock ? diag_rdata : presc_rdata);
        presc_sel = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        exp_st = 8'h01;
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after release");
        check_narrow(1'b1);
        check_presc(1'b0);

        do_write(16'h8000, 1'b1, 4'h0); check_state("R9 dgm set in normal mode");
        do_write(16'h4000, 1'b1, 4'h0); check_state("R8 enter diag");
        check_presc(1'b0);
        check_presc(1'b1);
        do_write(16'h0080, 1'b1, 4'h0); check_state("R9 type7 store");
        do_write(16'h4040, 1'b1, 4'h0); check_state("R5 conflict holds mode");
        do_write(16'h0F00, 1'b1, 4'h0); check_state("R4 bits 11..8 ignored");
        do_write(16'hF000, 1'b0, 4'h0); check_state("R6 narrow write ignored");
        do_write(16'h3000, 1'b1, 4'h0); check_state("R3 set ssht and pbb");
        do_write(16'h000F, 1'b1, 4'b0101); check_state("R7 hw beats clear");
        do_write(16'h0000, 1'b1, 4'b1010); check_state("R7 hw set alone");
        do_write(16'h000F, 1'b1, 4'h0); check_state("R4 clear only flags");
        do_write(16'h00F0, 1'b1, 4'h0); check_state("R12 clear all mode bits");
        do_write(16'hC000, 1'b1, 4'h0); check_state("R12 diagonal to diag rx");
        check_narrow(1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] d;
            logic        w;
            logic [3:0]  hw;
            d  = 16'($urandom);
            w  = ($urandom % 5) != 0;
            hw = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            do_write(d, w, hw);
            check_state("R3/R4/R5/R7 random write");
            if ((i % 7) == 0) check_presc(1'($urandom));
            if ((i % 11) == 0) check_narrow(1'($urandom));
        end

        finish_run();
    end

endmodule